// File: doc/BRIEF.md
# Single-Precision Reciprocal Square Root Estimator

This block accepts one IEEE 754 single-precision operand per cycle and returns a low-precision estimate of 1/sqrt(x), with an invalid flag and a divide-by-zero flag. It serves as the seed for an iterative refinement step, where a Newton-Raphson pass supplies the accuracy the seed lacks. The unit first sorts special operands into fixed answers, checking them in a fixed priority. A denormal operand counts as zero.

For an ordinary positive operand, the mantissa is scaled into [0.25, 1.0) without changing the parity of the exponent. Seven mantissa bits and the exponent parity select an 8-bit estimate. The unit takes that estimate from a constant table, which it computes at elaboration time from an exact integer test. It then packs the halved exponent and the estimate into a single-precision result.

The result, the flags and a valid strobe are registered, and they appear one cycle after the operand.

Top module: `rsqrt_est_f32`

## Requirements
- R1: An operand with exponent field 0xFF and a non-zero fraction is a NaN. It yields 0x7FC00000. The invalid flag is raised only when fraction bit 22 is 0 (signaling). The divide-by-zero flag stays low.
- R2: An operand with exponent field 0 (zero or denormal) yields infinity with the operand's sign (0x7F800000 or 0xFF800000) and raises divide-by-zero only.
- R3: A negative operand that is neither a NaN nor zero/denormal yields 0x7FC00000 and raises invalid. This includes negative infinity.
- R4: Positive infinity yields 0x00000000 with both flags low.
- R5: The special cases are checked in this priority: NaN, then zero/denormal, then negative, then infinity. As a result, a negative NaN follows R1 and a negative zero or denormal follows R2.
- R6: For a positive normal operand with biased exponent e, the result exponent field (bits 30:23) equals floor((380 − e) / 2).
- R7: For a positive normal operand, result bit 31 is 0, result bits 14:0 are 0, and both flags stay low.
- R8: For a positive normal operand, result bits 22:15 hold s − 256, where s = round(256 / sqrt(((q + 0.5)/N))) and q = 128 + fraction bits 22:16. N is 512 when exponent bit 0 is 1 (mantissa placed in [0.25, 0.5)) and 256 when it is 0 (mantissa placed in [0.5, 1.0)).
- R9: The strobe out_valid rises exactly one cycle after in_valid. Both flags are low in every cycle where out_valid is low.
- R10: While reset is asserted, and in the first cycle after it, out_valid and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_res | output | 32 | Single-precision estimate |
| out_invalid | output | 1 | Invalid-operation flag, qualified by out_valid |
| out_divzero | output | 1 | Divide-by-zero flag, qualified by out_valid |

## Verification
The operand patterns fall into four groups, and each group separates a different class of fault.

- **Special operands.** Every special class is applied with both signs, including a signaling and a quiet NaN and a negative denormal. These show whether the priority and the flag choice are correct or merely cover the common cases.
- **Table sweep.** All 256 estimator indices are walked at one odd and one even exponent. This exposes any table entry computed with the wrong divisor, the wrong rounding or a swapped parity.
- **Exponent range.** The smallest and largest normal operands probe both ends of the (380 − e)/2 mapping.
- **Random operands with idle gaps.** These mix all classes and check that the flags are never seen without the strobe.

// File: rtl/rsqrt_est_f32.sv
module rsqrt_est_f32 #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int EST_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [EXP_W+FRAC_W:0]    in_op,
  output logic                     out_valid,
  output logic [EXP_W+FRAC_W:0]    out_res,
  output logic                     out_invalid,
  output logic                     out_divzero
);
  localparam int W       = EXP_W + FRAC_W + 1;
  localparam int IDX_W   = EST_W;
  localparam int SEL_W   = IDX_W - 1;
  localparam int ROM_N   = 1 << IDX_W;
  localparam int LOW_W   = FRAC_W - EST_W;
  localparam int BIAS3   = 3 * ((1 << (EXP_W - 1)) - 1) - 1;
  localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [EST_W-1:0] est_fn(input int idx);
    longint d, lim, lo, t;
    d   = 2 * ((1 << SEL_W) + (idx % (1 << SEL_W))) + 1;
    lim = (idx >= (1 << SEL_W)) ? (64'sd1 <<< 28) : (64'sd1 <<< 27);
    lo  = 1 << EST_W;
    for (int b = EST_W - 1; b >= 0; b--) begin
      t = lo | (64'sd1 <<< b);
      if ((2 * t - 1) * (2 * t - 1) * d <= lim) lo = t;
    end
    return EST_W'(lo - (1 << EST_W));
  endfunction

  logic [EST_W-1:0] est_rom [ROM_N];
  for (genvar g = 0; g < ROM_N; g++) begin : g_rom
    assign est_rom[g] = est_fn(g);
  end

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  assign {sgn, ex, fr} = in_op;

  logic is_nan, is_zd, is_inf;
  assign is_nan = (ex == '1) && (fr != '0);
  assign is_inf = (ex == '1) && (fr == '0);
  assign is_zd  = (ex == '0);

  logic [EXP_W:0]   exp_dif;
  logic [EXP_W-1:0] exp_new;
  logic [IDX_W-1:0] idx;
  assign exp_dif = (EXP_W+1)'(BIAS3) - {1'b0, ex};
  assign exp_new = exp_dif[EXP_W:1];
  assign idx     = {ex[0], fr[FRAC_W-1 -: SEL_W]};

  logic unused_bits;
  assign unused_bits = ^{fr[LOW_W+SEL_W-EST_W:0], exp_dif[0]};

  logic [W-1:0] res_c;
  logic         inv_c, dz_c;
  always_comb begin
    res_c = {1'b0, exp_new, est_rom[idx], {LOW_W{1'b0}}};
    inv_c = 1'b0;
    dz_c  = 1'b0;
    if (is_nan) begin
      res_c = DNAN;
      inv_c = ~fr[FRAC_W-1];
    end else if (is_zd) begin
      res_c = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      dz_c  = 1'b1;
    end else if (sgn) begin
      res_c = DNAN;
      inv_c = 1'b1;
    end else if (is_inf) begin
      res_c = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_res     <= '0;
      out_invalid <= 1'b0;
      out_divzero <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_res     <= res_c;
      out_invalid <= in_valid & inv_c;
      out_divzero <= in_valid & dz_c;
    end
  end

  AST_STROBE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R9
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_invalid && !out_divzero); // R9
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_invalid, out_divzero})); // R5
  AST_NAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(is_nan) |-> out_res == DNAN && !out_divzero); // R1
  AST_DZ_INF: assert property (@(posedge clk) disable iff (!rst_n)
    out_divzero |-> out_res[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}); // R2
  AST_INV_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> out_res == DNAN); // R3
  AST_NORMAL_PACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(!sgn && ex != '0 && ex != '1) |->
      !out_res[W-1] && out_res[LOW_W-1:0] == '0 && !out_invalid && !out_divzero); // R7
endmodule

// File: tb/test_rsqrt_est_f32.sv
module test_rsqrt_est_f32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic        out_valid;
  logic [31:0] out_res;
  logic        out_invalid, out_divzero;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic        e_valid = 1'b0;
  logic [33:0] e_word = '0;
  string       e_tag = "R9";

  always #10 clk = ~clk;

  rsqrt_est_f32 i_rsqrt_est_f32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .out_valid(out_valid), .out_res(out_res),
    .out_invalid(out_invalid), .out_divzero(out_divzero));

  function automatic logic [33:0] model(input logic [31:0] x, output string tag);
    logic [7:0] e = x[30:23];
    logic [22:0] f = x[22:0];
    real a, r; int q, s, ex;
    if (e == 8'hff && f != 0) begin
      tag = x[31] ? "R5" : "R1";
      return {~f[22], 1'b0, 32'h7FC00000};
    end
    if (e == 0) begin
      tag = x[31] ? "R5" : "R2";
      return {2'b01, x[31], 8'hff, 23'h0};
    end
    if (x[31]) begin tag = "R3"; return {2'b10, 32'h7FC00000}; end
    if (e == 8'hff) begin tag = "R4"; return 34'h0; end
    tag = "R8";
    a = 1.0 + real'(f) / 8388608.0;
    a = e[0] ? a / 4.0 : a / 2.0;
    if (a < 0.5) begin
      q = $rtoi($floor(a * 512.0)); r = 1.0 / $sqrt((q + 0.5) / 512.0);
    end else begin
      q = $rtoi($floor(a * 256.0)); r = 1.0 / $sqrt((q + 0.5) / 256.0);
    end
    s  = $rtoi($floor(256.0 * r + 0.5));
    ex = (380 - int'(e)) / 2;
    return {2'b00, 1'b0, 8'(ex), 8'(s - 256), 15'h0};
  endfunction

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R9", {33'h0, out_valid}, {33'h0, e_valid});
    if (!e_valid)
      chk("R9", {32'h0, out_invalid, out_divzero}, 34'h0);
    else if (e_tag == "R8") begin
      chk("R6", {26'h0, out_res[30:23]}, {26'h0, e_word[30:23]});
      chk("R7", {out_invalid, out_divzero, out_res[31], 16'h0, out_res[14:0]}, 34'h0);
      chk("R8", {26'h0, out_res[22:15]}, {26'h0, e_word[22:15]});
    end else
      chk(e_tag, {out_invalid, out_divzero, out_res}, e_word);
  endtask

  task automatic step(input logic v, input logic [31:0] x);
    string t;
    @(negedge clk);
    compare();
    in_valid = v;
    in_op    = x;
    e_valid  = v;
    e_word   = model(x, t);
    e_tag    = t;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R10", {31'h0, out_valid, out_invalid, out_divzero}, 34'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", {31'h0, out_valid, out_invalid, out_divzero}, 34'h0);
    step(1, 32'h3F800000);
    step(1, 32'h40000000);
    step(1, 32'h40800000);
    step(1, 32'h3E800000);
    step(1, 32'h7F7FFFFF);
    step(1, 32'h00800000);
    step(1, 32'h7FC00001);
    step(1, 32'h7F800001);
    step(1, 32'hFF800001);
    step(1, 32'hFFC00000);
    step(1, 32'h00000000);
    step(1, 32'h80000000);
    step(1, 32'h00000001);
    step(1, 32'h80400000);
    step(0, 32'h7F800001);
    step(1, 32'hBF800000);
    step(1, 32'hFF800000);
    step(1, 32'h7F800000);
    step(0, 32'h00000000);
    for (int i = 0; i < 256; i++)
      step(1, {1'b0, (i >= 128) ? 8'd127 : 8'd128, 7'(i), 16'hA5C3});
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x = $urandom;
      if (i % 7 == 0) x[30:23] = ($urandom % 2) ? 8'hff : 8'h00;
      step(($urandom % 5) != 0, x);
    end
    step(0, 32'h0);
    step(0, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule